// File: doc/BRIEF.md
# Latched Bidirectional Port Translator

This block joins two eight-bit ports, an E side and a T side, and passes data across them in one direction at a time. A direction select picks the flow: when it is low, data entering on the E side leaves on the T side; when it is high, data entering on the T side leaves on the E side. A master output enable turns both ports off. A hold control picks between two modes. In transparent mode the enabled output follows its input. In held mode the output shows the last value stored.

Each side keeps its own holding register, and both registers load together whatever the direction. A change of direction while holding therefore shows what the newly enabled side stored earlier. Each physical port is modelled as three pieces: an input word, a per-bit "something drives this input" mask, and an output with a drive indication. A bit whose mask is clear reads as low, which models a pull-down resistor.

The E-side output uses a two-bit code per bit, so that a switched-off output is a distinct state and not an ordinary low. A switched-off T-side output is marked by its drive enable going low.

A parameter selects a variant that registers the three controls on the system clock.

Top module: `xlt_transceiver`

## Requirements
- R1: With the output enable high and the direction select low, the T output equals the E input, the T drive enable is 1, and every E output bit shows the cutoff code 2'b00 with the E drive flag at 0.
- R2: With the output enable high and the direction select high, each E output bit shows 2'b10 for a one and 2'b01 for a zero of the T-side data, the E drive flag is 1, the T drive enable is 0 and the T output is all zeros.
- R3: With the output enable low, every E output bit is 2'b00, both drive indications are 0 and the T output is all zeros, whatever the direction and hold controls are.
- R4: With the hold control low, the enabled output follows its input combinationally, within the same clock cycle that the input changes.
- R5: With the hold control high, the enabled output shows the input value sampled at the last rising clock edge at which the hold control was low. Later changes on either input have no effect on it.
- R6: Both sides' holding registers load at the same edges, whatever the direction. A direction change while holding shows the value stored for the newly selected input side, not that side's current input.
- R7: An input bit whose driven-mask bit is 0 reads as logic 0.
- R8: The E output code 2'b11 is never produced.
- R9: The E drive flag and the T drive enable are never 1 at the same time.
- R10: With the clocked-control parameter set to 1, the output enable, direction and hold controls take effect one clock cycle after they change.
- R11: Reset clears both holding registers, so a hold that begins before reset is released shows all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the holding registers load on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| outEn | input | 1 | Master output enable; low turns both sides off |
| dirSel | input | 1 | Direction: 0 moves E to T, 1 moves T to E |
| holdEn | input | 1 | 0 transparent, 1 hold stored data |
| eIn | input | WIDTH | E-side input data |
| eInDriven | input | WIDTH | Per-bit mask: 1 when the E input bit is driven |
| eOut | output | WIDTH x 2 | E-side output code per bit: 00 cutoff, 01 low, 10 high |
| eDrive | output | 1 | 1 when the E side drives |
| tIn | input | WIDTH | T-side input data |
| tInDriven | input | WIDTH | Per-bit mask: 1 when the T input bit is driven |
| tOut | output | WIDTH | T-side output data, zero when not driving |
| tOe | output | WIDTH | T-side drive enable, 1 for every bit when driving |

## Verification
In the default variant, every output is a combinational function of the controls, the inputs and the stored values. The bench therefore drives each stimulus on a falling clock edge and samples two nanoseconds later, still inside the same clock cycle. A stored value loads at the first rising edge after a stimulus that has the hold control low, so each held-mode expectation is taken from the stimulus one step before the hold control rose. In the clocked-control variant, a control change shows up only after the next rising edge. The bench samples that instance once before that edge, expecting the old controls, and once in the following cycle, expecting the new ones.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    E_CUT  = 2'b00,
    E_LOW  = 2'b01,
    E_HIGH = 2'b10
  } eCode_t;

  typedef struct packed {
    logic eDrive;
    logic tDrive;
    logic hold;
  } xltStrobe_t;
endpackage

// File: rtl/xlt_ctrl.sv
module xlt_ctrl #(
  parameter bit SYNC_CTRL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic outEn,
  input  logic dirSel,
  input  logic holdEn,
  output xlt_pkg::xltStrobe_t strobe
);
  logic oeEff, dirEff, holdEff;

  generate
    if (SYNC_CTRL) begin : g_sync
      logic oeQ, dirQ, holdQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          oeQ   <= 1'b0;
          dirQ  <= 1'b0;
          holdQ <= 1'b0;
        end else begin
          oeQ   <= outEn;
          dirQ  <= dirSel;
          holdQ <= holdEn;
        end
      end
      assign oeEff   = oeQ;
      assign dirEff  = dirQ;
      assign holdEff = holdQ;

      // R10: the strobes follow the ports one cycle late
      a_r10_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (strobe.eDrive == $past(outEn && dirSel)) &&
                        (strobe.hold == $past(holdEn)));
    end else begin : g_async
      assign oeEff   = outEn;
      assign dirEff  = dirSel;
      assign holdEff = holdEn;
    end
  endgenerate

  always_comb begin
    strobe.eDrive = oeEff & dirEff;
    strobe.tDrive = oeEff & ~dirEff;
    strobe.hold   = holdEff;
  end
endmodule

// File: rtl/xlt_datapath.sv
module xlt_datapath #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  xlt_pkg::xltStrobe_t strobe,
  input  logic [WIDTH-1:0] eIn,
  input  logic [WIDTH-1:0] eInDriven,
  input  logic [WIDTH-1:0] tIn,
  input  logic [WIDTH-1:0] tInDriven,
  output logic [WIDTH-1:0][1:0] eOut,
  output logic [WIDTH-1:0] tOut,
  output logic [WIDTH-1:0] tOe
);
  import xlt_pkg::*;

  logic [WIDTH-1:0] eSeen, tSeen;
  logic [WIDTH-1:0] eHeld, tHeld;
  logic [WIDTH-1:0] ePath, tPath;

  assign eSeen = eIn & eInDriven;
  assign tSeen = tIn & tInDriven;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eHeld <= '0;
      tHeld <= '0;
    end else if (!strobe.hold) begin
      eHeld <= eSeen;
      tHeld <= tSeen;
    end
  end

  assign ePath = strobe.hold ? eHeld : eSeen;
  assign tPath = strobe.hold ? tHeld : tSeen;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
        if (!strobe.eDrive)  eOut[i] = E_CUT;
        else if (tPath[i])   eOut[i] = E_HIGH;
        else                 eOut[i] = E_LOW;
      end
      assign tOut[i] = strobe.tDrive & ePath[i];
      assign tOe[i]  = strobe.tDrive;

      // R8: no illegal code on any bit
      a_r8_no_illegal_code: assert property (@(posedge clk) disable iff (!rstN)
        eOut[i] != 2'b11);
    end
  endgenerate

  // R3: a side that does not drive shows cutoff and zeros
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.eDrive && !strobe.tDrive) |-> (eOut == '0) && (tOut == '0));

  // R5: two held cycles in a row leave the driven T output unchanged
  a_r5_held_stable: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && strobe.hold && $past(strobe.hold) &&
     strobe.tDrive && $past(strobe.tDrive)) |-> $stable(tOut));
endmodule

// File: rtl/xlt_transceiver.sv
module xlt_transceiver #(
  parameter int WIDTH     = 8,
  parameter bit SYNC_CTRL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic outEn,
  input  logic dirSel,
  input  logic holdEn,
  input  logic [WIDTH-1:0] eIn,
  input  logic [WIDTH-1:0] eInDriven,
  output logic [WIDTH-1:0][1:0] eOut,
  output logic eDrive,
  input  logic [WIDTH-1:0] tIn,
  input  logic [WIDTH-1:0] tInDriven,
  output logic [WIDTH-1:0] tOut,
  output logic [WIDTH-1:0] tOe
);
  xlt_pkg::xltStrobe_t strobe;

  xlt_ctrl #(.SYNC_CTRL(SYNC_CTRL)) u_ctrl (
    .clk(clk), .rstN(rstN), .outEn(outEn), .dirSel(dirSel),
    .holdEn(holdEn), .strobe(strobe)
  );

  xlt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .eIn(eIn), .eInDriven(eInDriven), .tIn(tIn), .tInDriven(tInDriven),
    .eOut(eOut), .tOut(tOut), .tOe(tOe)
  );

  assign eDrive = strobe.eDrive;

  // R9: never both sides driving
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !(eDrive && (tOe != '0)));

  // R1: while T drives, the E side must be cut off
  a_r1_input_side_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (tOe != '0) |-> (eOut == '0));
endmodule

// File: tb/sim_xlt_transceiver.sv
`timescale 1ns/1ps
module sim_xlt_transceiver;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outEn, dirSel, holdEn;
  logic [W-1:0] eIn, eInDriven, tIn, tInDriven;
  logic [W-1:0][1:0] eOut0, eOut1;
  logic eDrive0, eDrive1;
  logic [W-1:0] tOut0, tOut1, tOe0, tOe1;

  always #2.5 clk = ~clk;

  xlt_transceiver #(.WIDTH(W), .SYNC_CTRL(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .outEn(outEn), .dirSel(dirSel), .holdEn(holdEn),
    .eIn(eIn), .eInDriven(eInDriven), .eOut(eOut0), .eDrive(eDrive0),
    .tIn(tIn), .tInDriven(tInDriven), .tOut(tOut0), .tOe(tOe0));

  xlt_transceiver #(.WIDTH(W), .SYNC_CTRL(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .outEn(outEn), .dirSel(dirSel), .holdEn(holdEn),
    .eIn(eIn), .eInDriven(eInDriven), .eOut(eOut1), .eDrive(eDrive1),
    .tIn(tIn), .tInDriven(tInDriven), .tOut(tOut1), .tOe(tOe1));

  typedef struct {
    bit           which;
    logic [2*W-1:0] eExp;
    logic [W-1:0] tExp;
    logic         tDrv;
    string        tag;
  } item_t;

  item_t sbq[$];
  int nChecks = 0;
  int nFails = 0;

  function automatic logic [2*W-1:0] levels(input logic [W-1:0] d);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = d[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic oe, input logic dir, input logic le,
                       input logic [W-1:0] a, input logic [W-1:0] av,
                       input logic [W-1:0] b, input logic [W-1:0] bv);
    @(negedge clk);
    outEn = oe; dirSel = dir; holdEn = le;
    eIn = a; eInDriven = av; tIn = b; tInDriven = bv;
  endtask

  task automatic expect_out(input bit which, input logic [2*W-1:0] e,
                            input logic [W-1:0] t, input logic td, input string tag);
    item_t it;
    it.which = which; it.eExp = e; it.tExp = t; it.tDrv = td; it.tag = tag;
    sbq.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        logic [2*W-1:0] eA;
        logic [W-1:0] tA, oeA;
        logic edA;
        it = sbq.pop_front();
        eA  = it.which ? eOut1 : eOut0;
        tA  = it.which ? tOut1 : tOut0;
        oeA = it.which ? tOe1 : tOe0;
        edA = it.which ? eDrive1 : eDrive0;
        check(it.tag, "E code", eA, it.eExp);
        check(it.tag, "T data", {{W{1'b0}}, tA}, {{W{1'b0}}, it.tExp});
        check(it.tag, "T enable", {{W{1'b0}}, oeA}, {{W{1'b0}}, {W{it.tDrv}}});
        check(it.tag, "E drive", {{(2*W-1){1'b0}}, edA},
              {{(2*W-1){1'b0}}, (it.eExp != '0)});
        check("R9", "contention", {{(2*W-1){1'b0}}, edA && (oeA != '0)}, '0);
        for (int i = 0; i < W; i++)
          check("R8", "illegal code", {{(2*W-2){1'b0}}, eA[2*i +: 2] == 2'b11}, '0);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  localparam logic [W-1:0] ALL = '1;

  initial begin : stim
    outEn = 1'b1; dirSel = 1'b1; holdEn = 1'b1;
    eIn = 8'hFF; eInDriven = ALL; tIn = 8'hFF; tInDriven = ALL;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: hold since reset shows cleared store
    drive(1, 1, 1, 8'hFF, ALL, 8'hFF, ALL);
    expect_out(0, levels(8'h00), 8'h00, 0, "R11");
    // R1 R4: E to T transparent
    drive(1, 0, 0, 8'hA5, ALL, 8'h00, ALL);
    expect_out(0, '0, 8'hA5, 1, "R1");
    drive(1, 0, 0, 8'h3C, ALL, 8'h00, ALL);
    expect_out(0, '0, 8'h3C, 1, "R4");
    // R2 R4: T to E transparent
    drive(1, 1, 0, 8'h00, ALL, 8'h96, ALL);
    expect_out(0, levels(8'h96), 8'h00, 0, "R2");
    drive(1, 1, 0, 8'h00, ALL, 8'h0F, ALL);
    expect_out(0, levels(8'h0F), 8'h00, 0, "R4");
    // R7: undriven bits read low
    drive(1, 1, 0, 8'h00, ALL, 8'hFF, 8'hF0);
    expect_out(0, levels(8'hF0), 8'h00, 0, "R7");
    // load both stores: E=5A, T=C3
    drive(1, 1, 0, 8'h5A, ALL, 8'hC3, ALL);
    expect_out(0, levels(8'hC3), 8'h00, 0, "R4");
    // R5: hold, inputs change
    drive(1, 1, 1, 8'h22, ALL, 8'h11, ALL);
    expect_out(0, levels(8'hC3), 8'h00, 0, "R5");
    // R6: direction flip while holding shows stored E value
    drive(1, 0, 1, 8'h22, ALL, 8'h11, ALL);
    expect_out(0, '0, 8'h5A, 1, "R6");
    // R3: output enable low, either direction or hold
    drive(0, 0, 1, 8'hFF, ALL, 8'hFF, ALL);
    expect_out(0, '0, 8'h00, 0, "R3");
    drive(0, 1, 0, 8'hFF, ALL, 8'hFF, ALL);
    expect_out(0, '0, 8'h00, 0, "R3");
    // R10: clocked variant still off before the edge
    drive(1, 0, 0, 8'h22, ALL, 8'h00, ALL);
    expect_out(0, '0, 8'h22, 1, "R4");
    expect_out(1, '0, 8'h00, 0, "R10");
    drive(1, 0, 0, 8'h22, ALL, 8'h00, ALL);
    expect_out(1, '0, 8'h22, 1, "R10");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule